// File: doc/BRIEF.md
# Reservation-Based Atomic Memory Unit

This block sits in front of a small shared word memory that several processors reach through a single port. Each cycle a round-robin arbiter picks one pending request. The unit then performs it in full before the next request is taken, so every operation is indivisible with respect to all the others. Besides plain loads and stores, the unit offers four synchronization operations: a linked load, a conditional store, an atomic exchange and a fetch-and-increment.

For each processor the unit holds one reservation, made of a valid bit and the linked address. A linked load sets the issuing processor's reservation. Any write that actually lands on an address destroys every reservation that points at that address. A conditional store commits only while the issuer's own reservation is still alive. Software builds locks on this unit: 0 means free and 1 means taken. An exchange with 1 that returns 0 acquires the lock, and a plain store of 0 releases it.

Top module: `llsc_atomic_unit`

## Requirements
- R1: A plain store (op code 1) writes `wdata` and responds with 0. A plain load (op code 0, and the unused codes 6 and 7) responds with the word held at the address and changes nothing.
- R2: A linked load (op code 2) responds with the current word and arms the issuing processor's reservation on that address.
- R3: A conditional store (op code 3) whose issuer holds a live reservation on the same address writes `wdata` and responds with 1.
- R4: When another processor's write reaches the linked address between a linked load and the conditional store, the conditional store responds with 0 and leaves memory unchanged. This includes a winning conditional store in the same arbitration burst.
- R5: A conditional store from a processor with no reservation, or with a reservation on a different address, responds with 0 and writes nothing.
- R6: Every conditional store, whether it succeeds or fails, disarms the issuer's reservation, so an immediate repeat fails.
- R7: An exchange (op code 4) responds with the previous word and writes `wdata` in the same operation. With 1 written, a response of 0 means the lock was obtained and a response of 1 means it was already held.
- R8: A fetch-and-increment (op code 5) responds with the previous word and stores that word plus one, wrapping from all ones to 0.
- R9: At most one request is granted per cycle (`req_ready` is one-hot or zero). The response appears on the following cycle with `rsp_id` equal to the granted processor. With several processors waiting, grants rotate starting after the last granted index.
- R10: Any write that takes effect (store, exchange, increment or successful conditional store) disarms the reservations of all processors on that address. Reservations on other addresses survive.
- R11: After reset all memory words read 0, no reservation is armed and `rsp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | N_CPU | Per-processor request pending, held until granted |
| req_op | input | N_CPU*3 | Per-processor op code, 3 bits each |
| req_addr | input | N_CPU*AW | Per-processor word address |
| req_wdata | input | N_CPU*DW | Per-processor write value |
| req_ready | output | N_CPU | One-hot grant; request is consumed at this clock edge |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | IDW | Index of the processor being answered |
| rsp_data | output | DW | Old word, success flag, or 0 for a plain store |

## Verification
The interesting collision is between two conditional stores to the same address. Each comes from a processor holding a reservation there, and both are presented in the same cycle. The bench arms both reservations and raises both requests on one edge. It lets the arbiter serialize them and then judges the pair. Exactly one response must be a 1, the two ids must differ, and a later load must return the winner's data. A second same-cycle case presents four loads at once, and each grant must follow its predecessor in rotating order.

// File: rtl/llsc_atomic_unit.sv
`timescale 1ns/1ps
module llsc_atomic_unit #(
  parameter int N_CPU = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  localparam int IDW  = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_CPU-1:0]    req_valid,
  input  logic [N_CPU*3-1:0]  req_op,
  input  logic [N_CPU*AW-1:0] req_addr,
  input  logic [N_CPU*DW-1:0] req_wdata,
  output logic [N_CPU-1:0]    req_ready,
  output logic                rsp_valid,
  output logic [IDW-1:0]      rsp_id,
  output logic [DW-1:0]       rsp_data
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] OP_ST = 3'd1, OP_LL = 3'd2, OP_SC = 3'd3,
                         OP_SWP = 3'd4, OP_INC = 3'd5;

  logic [DW-1:0]  mem [DEPTH];
  logic [N_CPU-1:0] resv_v;
  logic [AW-1:0]  resv_a [N_CPU];
  logic [IDW-1:0] last_q;

  logic           g_hit;
  logic [IDW-1:0] g_id;
  logic [2:0]     g_op;
  logic [AW-1:0]  g_addr;
  logic [DW-1:0]  g_wdata, old, wr_val, rv;
  logic           own_ok, wr_en;

  always_comb begin
    g_hit = 1'b0;
    g_id  = '0;
    for (int k = 1; k <= N_CPU; k++) begin
      int j;
      j = (int'(last_q) + k) % N_CPU;
      if (!g_hit && req_valid[j]) begin
        g_hit = 1'b1;
        g_id  = IDW'(j);
      end
    end
  end

  assign req_ready = g_hit ? (N_CPU'(1) << g_id) : '0;
  assign g_op      = req_op[g_id*3 +: 3];
  assign g_addr    = req_addr[g_id*AW +: AW];
  assign g_wdata   = req_wdata[g_id*DW +: DW];
  assign old       = mem[g_addr];
  assign own_ok    = resv_v[g_id] && (resv_a[g_id] == g_addr);
  assign wr_en     = g_hit && (g_op == OP_ST || g_op == OP_SWP || g_op == OP_INC ||
                               (g_op == OP_SC && own_ok));
  assign wr_val    = (g_op == OP_INC) ? old + DW'(1) : g_wdata;

  always_comb begin
    case (g_op)
      OP_ST:   rv = '0;
      OP_SC:   rv = DW'(own_ok);
      default: rv = old;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      for (int p = 0; p < N_CPU; p++) resv_a[p] <= '0;
      resv_v    <= '0;
      last_q    <= IDW'(N_CPU - 1);
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= g_hit;
      if (g_hit) begin
        rsp_id   <= g_id;
        rsp_data <= rv;
        last_q   <= g_id;
      end
      if (wr_en) mem[g_addr] <= wr_val;
      for (int p = 0; p < N_CPU; p++)
        if (wr_en && resv_a[p] == g_addr) resv_v[p] <= 1'b0;
      if (g_hit && g_op == OP_LL) begin
        resv_v[g_id] <= 1'b1;
        resv_a[g_id] <= g_addr;
      end
      if (g_hit && g_op == OP_SC) resv_v[g_id] <= 1'b0;
    end
  end

  assert_one_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ready));
  assert_rsp_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_valid) |=> (rsp_valid && rsp_id == $past(g_id)));
  assert_ll_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (g_hit && g_op == OP_LL) |=> (resv_v[$past(g_id)] && resv_a[$past(g_id)] == $past(g_addr)));
  assert_sc_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (g_hit && g_op == OP_SC && !own_ok) |=> (rsp_data == '0 && mem[$past(g_addr)] == $past(old)));
  assert_sc_disarm_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (g_hit && g_op == OP_SC) |=> !resv_v[$past(g_id)]);
  assert_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (g_hit && g_op == OP_INC) |=> (mem[$past(g_addr)] == $past(old) + DW'(1) && rsp_data == $past(old)));
endmodule

// File: tb/sim_llsc_atomic_unit.sv
`timescale 1ns/1ps
module sim_llsc_atomic_unit;
  localparam int N = 4, AW = 4, DW = 16;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] req_valid = '0;
  logic [N*3-1:0] req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0] req_ready;
  logic rsp_valid;
  logic [1:0] rsp_id;
  logic [DW-1:0] rsp_data;
  int errors = 0, checks = 0, cyc = 0;

  llsc_atomic_unit #(.N_CPU(N), .AW(AW), .DW(DW)) u0 (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic put(int p, logic [2:0] op, int a, logic [DW-1:0] d);
    req_op[p*3 +: 3] = op;
    req_addr[p*AW +: AW] = AW'(a);
    req_wdata[p*DW +: DW] = d;
    req_valid[p] = 1'b1;
  endtask

  task automatic do_op(int p, logic [2:0] op, int a, logic [DW-1:0] d, output logic [DW-1:0] r);
    @(negedge clk);
    put(p, op, a, d);
    #1;
    while (!req_ready[p]) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid[p] = 1'b0;
    r = rsp_data;
    chk("R9 rsp id", {rsp_valid, 13'd0, rsp_id}, {1'b1, 13'd0, 2'(p)});
  endtask

  logic [DW-1:0] r;

  task automatic t_reset();
    chk("R11 rsp_valid", {15'd0, rsp_valid}, 16'd0);
    chk("R11 ready idle", {12'd0, req_ready}, 16'd0);
    do_op(0, 3'd0, 3, 16'h5, r); chk("R11 mem zero", r, 16'h0);
  endtask

  task automatic t_plain();
    do_op(0, 3'd1, 1, 16'h1234, r); chk("R1 store rsp", r, 16'h0);
    do_op(2, 3'd0, 1, 16'h0, r);    chk("R1 load", r, 16'h1234);
    do_op(1, 3'd7, 1, 16'hBEEF, r); chk("R1 unused code reads", r, 16'h1234);
    do_op(1, 3'd0, 1, 16'h0, r);    chk("R1 unused code no write", r, 16'h1234);
  endtask

  task automatic t_llsc_ok();
    do_op(1, 3'd1, 2, 16'd7, r);
    do_op(1, 3'd2, 2, 16'd0, r);  chk("R2 linked load value", r, 16'd7);
    do_op(1, 3'd3, 2, 16'd99, r); chk("R3 sc success", r, 16'd1);
    do_op(3, 3'd0, 2, 16'd0, r);  chk("R3 sc wrote", r, 16'd99);
    do_op(1, 3'd3, 2, 16'd55, r); chk("R6 repeat sc fails", r, 16'd0);
    do_op(3, 3'd0, 2, 16'd0, r);  chk("R6 repeat sc no write", r, 16'd99);
  endtask

  task automatic t_llsc_broken();
    do_op(0, 3'd2, 4, 16'd0, r);  chk("R2 ll fresh", r, 16'd0);
    do_op(3, 3'd1, 4, 16'd5, r);
    do_op(0, 3'd3, 4, 16'd8, r);  chk("R4 sc after foreign store", r, 16'd0);
    do_op(0, 3'd0, 4, 16'd0, r);  chk("R4 memory kept", r, 16'd5);
  endtask

  task automatic t_sc_mismatch();
    do_op(2, 3'd3, 6, 16'd9, r);  chk("R5 sc no reservation", r, 16'd0);
    do_op(2, 3'd0, 6, 16'd0, r);  chk("R5 no write", r, 16'd0);
    do_op(2, 3'd2, 7, 16'd0, r);
    do_op(2, 3'd3, 6, 16'd9, r);  chk("R5 sc other address", r, 16'd0);
    do_op(2, 3'd0, 6, 16'd0, r);  chk("R5 other address no write", r, 16'd0);
  endtask

  task automatic t_clear_all();
    do_op(0, 3'd2, 8, 16'd0, r);
    do_op(1, 3'd2, 8, 16'd0, r);
    do_op(2, 3'd2, 9, 16'd0, r);
    do_op(3, 3'd5, 8, 16'd0, r);  chk("R8 finc old", r, 16'd0);
    do_op(0, 3'd3, 8, 16'd3, r);  chk("R10 p0 disarmed", r, 16'd0);
    do_op(1, 3'd3, 8, 16'd3, r);  chk("R10 p1 disarmed", r, 16'd0);
    do_op(2, 3'd3, 9, 16'd11, r); chk("R10 other address kept", r, 16'd1);
    do_op(0, 3'd2, 10, 16'd0, r);
    do_op(1, 3'd2, 10, 16'd0, r);
    do_op(1, 3'd3, 10, 16'd3, r); chk("R3 p1 sc wins", r, 16'd1);
    do_op(0, 3'd3, 10, 16'd4, r); chk("R10 sc by other disarms", r, 16'd0);
    do_op(0, 3'd0, 10, 16'd0, r); chk("R10 value from winner", r, 16'd3);
  endtask

  task automatic t_lock();
    do_op(1, 3'd4, 12, 16'd1, r); chk("R7 acquire free lock", r, 16'd0);
    do_op(2, 3'd4, 12, 16'd1, r); chk("R7 lock busy", r, 16'd1);
    do_op(1, 3'd1, 12, 16'd0, r);
    do_op(2, 3'd4, 12, 16'd1, r); chk("R7 acquire after release", r, 16'd0);
    do_op(2, 3'd0, 12, 16'd0, r); chk("R7 lock taken", r, 16'd1);
  endtask

  task automatic t_finc();
    do_op(3, 3'd1, 13, 16'hFFFF, r);
    do_op(3, 3'd5, 13, 16'd0, r);  chk("R8 finc old at top", r, 16'hFFFF);
    do_op(0, 3'd0, 13, 16'd0, r);  chk("R8 wrap to zero", r, 16'd0);
    do_op(1, 3'd5, 13, 16'd0, r);  chk("R8 finc second", r, 16'd0);
    do_op(0, 3'd0, 13, 16'd0, r);  chk("R8 incremented", r, 16'd1);
  endtask

  task automatic burst(int cnt, output int ids[4], output logic [DW-1:0] ds[4]);
    for (int n = 0; n < cnt; n++) begin
      int g;
      #1;
      g = -1;
      for (int p = 0; p < N; p++) if (req_ready[p]) g = p;
      @(negedge clk);
      ids[n] = int'(rsp_id);
      ds[n] = rsp_data;
      if (g >= 0) req_valid[g] = 1'b0;
      chk("R9 grant matches rsp id", 16'(ids[n]), 16'(g));
    end
  endtask

  task automatic t_race();
    int ids[4];
    logic [DW-1:0] ds[4];
    do_op(0, 3'd2, 14, 16'd0, r);
    do_op(1, 3'd2, 14, 16'd0, r);
    @(negedge clk);
    put(0, 3'd3, 14, 16'hA0);
    put(1, 3'd3, 14, 16'hB1);
    burst(2, ids, ds);
    chk("R4 one winner", ds[0] + ds[1], 16'd1);
    chk("R9 distinct ids", 16'(ids[0] != ids[1]), 16'd1);
    do_op(2, 3'd0, 14, 16'd0, r);
    chk("R4 winner data", r, (ds[0] == 1) ? (ids[0] == 0 ? 16'hA0 : 16'hB1)
                                         : (ids[1] == 0 ? 16'hA0 : 16'hB1));
  endtask

  task automatic t_rr();
    int ids[4];
    logic [DW-1:0] ds[4];
    @(negedge clk);
    for (int p = 0; p < N; p++) put(p, 3'd0, 1, 16'd0);
    burst(4, ids, ds);
    for (int n = 1; n < 4; n++)
      chk("R9 rotating order", 16'(ids[n]), 16'((ids[n-1] + 1) % N));
    for (int n = 0; n < 4; n++) chk("R1 burst load", ds[n], 16'h1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_llsc_ok();
    t_llsc_broken();
    t_sc_mismatch();
    t_clear_all();
    t_lock();
    t_finc();
    t_race();
    t_rr();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule